// File: doc/BRIEF.md
# Incremental Pseudo-Linear Expression Evaluator

This block tracks the value of `C_I*i + C_J*DIV(j,D1) + MOD(C_K*k,D2) + C0` while an external loop controller walks three nested iterators: `i` is the outermost, `j` the middle and `k` the innermost. The datapath has no multiplier and no divider. Each product is kept as a running sum, and each modulo term is a small wrapping counter. The scaled quotient is rewritten as `C_J*(j - MOD(j,D1))/D1`. This running sum moves by `C_J` only when the residue of `j` wraps to zero. It never moves in other cycles.

The controller raises `adv_i` for one cycle for each change of iteration point. In that cycle it says for each iterator whether the iterator steps up by one or restarts at its lower bound. The new expression value appears on `val_o`, with `valid_o`, in the next cycle. Bounds, coefficients, divisors and the constant are parameters. `C_J` must be a multiple of `D1`, and all iterator values are non-negative.

Top module: `pexpr_eval`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `val_o` is 0 and `valid_o` is 0.
- R2: `valid_o` is 1 in exactly those cycles that follow a rising clock edge at which `adv_i` was 1. This holds for isolated advances and for back-to-back advances.
- R3: When `valid_o` is 1, `val_o` equals `C_I*i + C_J*floor(j/D1) + ((C_K*k) mod D2) + C0` for the current iterator values. It is a two's-complement value of `OUT_W` bits.
- R4: On an advance, bit x of `wrap_i` reloads iterator x with its lower bound. Bit 0 selects k, bit 1 selects j and bit 2 selects i. A set `wrap_i` bit overrides the `inc_i` bit of the same iterator.
- R5: On an advance, bit x of `inc_i` (same bit order as R4) raises iterator x by one. If neither bit of an iterator is set, that iterator keeps its value.
- R6: While `adv_i` is 0, `inc_i` and `wrap_i` have no effect. The iterator state and `val_o` both hold.
- R7: Each modulo counter stays within 0 to its divisor minus one. After an addition, the counter is corrected by one subtraction or one addition of the divisor.
- R8: An iterator stepped past its upper bound keeps following the formula of R3. It is not clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance to a new iteration point |
| inc_i | input | 3 | Step request per iterator (bit 0 k, bit 1 j, bit 2 i) |
| wrap_i | input | 3 | Restart-to-lower-bound request per iterator (same order) |
| val_o | output | OUT_W | Signed expression value |
| valid_o | output | 1 | `val_o` was updated by the previous advance |

## Verification
The assertions check on every cycle that the modulo counters stay in range and that each accumulator moves by exactly its coefficient on a step. They also check that a restart lands on the lower-bound value, and that output and state freeze whenever no advance is requested. Only the bench scenarios can show that the assembled value matches direct integer evaluation. The bench covers every point of the full nested sweep, restart priority, running past the upper bound, back-to-back advances, and reset in the middle of a run.

// File: rtl/pexpr_pkg.sv
package pexpr_pkg;
  localparam int N_ITER = 3;

  typedef enum int {
    ITER_K = 0,
    ITER_J = 1,
    ITER_I = 2
  } iter_e;

  // floor-style modulo, result in [0, d-1]
  function automatic int mod_floor(int a, int d);
    int r;
    r = a % d;
    return (r < 0) ? r + d : r;
  endfunction
endpackage

// File: rtl/pexpr_lin_acc.sv
module pexpr_lin_acc #(
  parameter int W    = 16,
  parameter int COEF = 1,
  parameter int INIT = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_i,
  input  logic                add_i,
  output logic signed [W-1:0] nxt_o,
  output logic signed [W-1:0] q_o
);
  localparam logic signed [W-1:0] COEF_V = W'(COEF);
  localparam logic signed [W-1:0] INIT_V = W'(INIT);

  always_comb begin
    nxt_o = q_o;
    if (ld_i)       nxt_o = INIT_V;
    else if (add_i) nxt_o = q_o + COEF_V;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= INIT_V;
    else         q_o <= nxt_o;
  end

  assert_acc_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == INIT_V);
  assert_acc_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_i && !ld_i) |=> q_o == $past(q_o) + COEF_V);
endmodule

// File: rtl/pexpr_mod_ctr.sv
module pexpr_mod_ctr #(
  parameter int D    = 3,
  parameter int STEP = 1,
  parameter int INIT = 0,
  parameter int CW   = $clog2(D) + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ld_i,
  input  logic                 step_i,
  output logic signed [CW-1:0] nxt_o,
  output logic signed [CW-1:0] q_o,
  output logic                 wrap_o
);
  localparam logic signed [CW-1:0] D_V    = CW'(D);
  localparam logic signed [CW-1:0] STEP_V = CW'(STEP % D);
  localparam logic signed [CW-1:0] INIT_V = CW'(INIT);

  logic signed [CW-1:0] sum;

  always_comb begin
    sum    = q_o + STEP_V;
    nxt_o  = q_o;
    wrap_o = 1'b0;
    if (ld_i) begin
      nxt_o = INIT_V;
    end else if (step_i) begin
      if (sum >= D_V) begin
        nxt_o  = sum - D_V;
        wrap_o = 1'b1;
      end else if (sum[CW-1]) begin
        nxt_o  = sum + D_V;
        wrap_o = 1'b1;
      end else begin
        nxt_o = sum;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= INIT_V;
    else         q_o <= nxt_o;
  end

  assert_mod_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_o[CW-1] && (q_o < D_V));
  assert_mod_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == INIT_V);
endmodule

// File: rtl/pexpr_eval.sv
module pexpr_eval
  import pexpr_pkg::*;
#(
  parameter int OUT_W = 16,
  parameter int I_LO  = 2,
  parameter int J_LO  = 0,
  parameter int K_LO  = 1,
  parameter int C_I   = 81,
  parameter int C_J   = 15,
  parameter int D1    = 5,
  parameter int C_K   = 5,
  parameter int D2    = 3,
  parameter int C0    = -78
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  input  logic [N_ITER-1:0]       inc_i,
  input  logic [N_ITER-1:0]       wrap_i,
  output logic signed [OUT_W-1:0] val_o,
  output logic                    valid_o
);
  localparam int JW = $clog2(D1) + 2;
  localparam int KW = $clog2(D2) + 2;
  // lower-bound reload values, elaboration-time constants
  localparam int ACC_I0 = C_I * I_LO;
  localparam int DIVJ0  = C_J * (J_LO / D1);
  localparam int MODJ0  = mod_floor(J_LO, D1);
  localparam int MODK0  = mod_floor(C_K * K_LO, D2);

  logic [N_ITER-1:0] ld, step;
  assign ld   = {N_ITER{adv_i}} & wrap_i;
  assign step = {N_ITER{adv_i}} & inc_i & ~wrap_i;

  logic signed [OUT_W-1:0] acc_i_nxt, acc_i_q;
  logic signed [OUT_W-1:0] divj_nxt, divj_q;
  logic signed [JW-1:0]    modj_nxt, modj_q;
  logic signed [KW-1:0]    modk_nxt, modk_q;
  logic                    modj_wrap, modk_wrap;

  pexpr_lin_acc #(.W(OUT_W), .COEF(C_I), .INIT(ACC_I0)) u_acc_i (
    .clk_i, .rst_ni, .ld_i(ld[ITER_I]), .add_i(step[ITER_I]),
    .nxt_o(acc_i_nxt), .q_o(acc_i_q));

  // residue of j; a wrap means j crossed a multiple of D1
  pexpr_mod_ctr #(.D(D1), .STEP(1), .INIT(MODJ0), .CW(JW)) u_mod_j (
    .clk_i, .rst_ni, .ld_i(ld[ITER_J]), .step_i(step[ITER_J]),
    .nxt_o(modj_nxt), .q_o(modj_q), .wrap_o(modj_wrap));

  // C_J*DIV(j,D1) = (C_J/D1)*(j - MOD(j,D1)): moves by C_J only on residue wrap
  pexpr_lin_acc #(.W(OUT_W), .COEF(C_J), .INIT(DIVJ0)) u_div_j (
    .clk_i, .rst_ni, .ld_i(ld[ITER_J]), .add_i(step[ITER_J] & modj_wrap),
    .nxt_o(divj_nxt), .q_o(divj_q));

  pexpr_mod_ctr #(.D(D2), .STEP(C_K), .INIT(MODK0), .CW(KW)) u_mod_k (
    .clk_i, .rst_ni, .ld_i(ld[ITER_K]), .step_i(step[ITER_K]),
    .nxt_o(modk_nxt), .q_o(modk_q), .wrap_o(modk_wrap));

  logic signed [OUT_W-1:0] val_d;
  always_comb begin
    val_d = acc_i_nxt + divj_nxt + {{(OUT_W-KW){modk_nxt[KW-1]}}, modk_nxt}
          + OUT_W'(C0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= adv_i;
      if (adv_i) val_o <= val_d;
    end
  end

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> (!valid_o && $stable(val_o) && $stable(acc_i_q) && $stable(divj_q)
                && $stable(modj_q) && $stable(modk_q)));
  assert_div_on_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step[ITER_J] && !modj_wrap) |=> $stable(divj_q));
  assert_modk_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step[ITER_K] |-> !modk_wrap);
endmodule

// File: tb/tb_pexpr_eval.sv
module tb_pexpr_eval;
  localparam int OUT_W = 16;
  localparam int I_LO = 2, I_HI = 6;
  localparam int J_LO = 0, J_HI = 11;
  localparam int K_LO = 1, K_HI = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic adv_i = 1'b0;
  logic [2:0] inc_i = '0, wrap_i = '0;
  logic signed [OUT_W-1:0] val_o;
  logic valid_o;

  int errors = 0, checks = 0;
  int mi, mj, mk;

  always #5 clk = ~clk;

  pexpr_eval #(.OUT_W(OUT_W)) dut (
    .clk_i(clk), .rst_ni, .adv_i, .inc_i, .wrap_i, .val_o, .valid_o);

  function automatic int expv(int i, int j, int k);
    return 81 * i + 15 * (j / 5) + (((5 * k) % 3) + 3) % 3 - 78;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_upd(logic [2:0] inc, logic [2:0] wrp);
    if (wrp[0]) mk = K_LO; else if (inc[0]) mk++;
    if (wrp[1]) mj = J_LO; else if (inc[1]) mj++;
    if (wrp[2]) mi = I_LO; else if (inc[2]) mi++;
  endtask

  // one isolated advance, checked in the cycle after
  task automatic apply(logic [2:0] inc, logic [2:0] wrp, string req);
    @(negedge clk);
    inc_i = inc; wrap_i = wrp; adv_i = 1'b1;
    model_upd(inc, wrp);
    @(negedge clk);
    adv_i = 1'b0; inc_i = '0; wrap_i = '0;
    chk(valid_o == 1'b1, {req, " R2 valid"}, int'(valid_o), 1);
    chk(int'(val_o) == expv(mi, mj, mk), {req, " R3 value"}, int'(val_o), expv(mi, mj, mk));
  endtask

  task automatic t_reset;
    chk(val_o == '0, "R1 val at reset", int'(val_o), 0);
    chk(valid_o == 1'b0, "R1 valid at reset", int'(valid_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk(val_o == '0 && valid_o == 1'b0, "R1 after release", int'(val_o), 0);
  endtask

  task automatic t_sweep;
    apply(3'b000, 3'b111, "R4 start");
    for (int i = I_LO; i <= I_HI; i++)
      for (int j = J_LO; j <= J_HI; j++)
        for (int k = K_LO; k <= K_HI; k++) begin
          if (k < K_HI) apply(3'b001, 3'b000, "R5 step k");
          else if (j < J_HI) apply(3'b010, 3'b001, "R5 step j");
          else if (i < I_HI) apply(3'b100, 3'b011, "R5 step i");
        end
  endtask

  task automatic t_hold;
    int prev;
    apply(3'b000, 3'b111, "R4 restart all");
    apply(3'b011, 3'b000, "R5 step j,k");
    prev = int'(val_o);
    @(negedge clk); inc_i = 3'b111; wrap_i = 3'b111; adv_i = 1'b0;
    @(negedge clk);
    chk(valid_o == 1'b0, "R6 R2 no valid without adv", int'(valid_o), 0);
    chk(int'(val_o) == prev, "R6 val held", int'(val_o), prev);
    @(negedge clk); inc_i = '0; wrap_i = '0;
    apply(3'b001, 3'b000, "R6 state untouched");
  endtask

  task automatic t_prio;
    apply(3'b010, 3'b000, "R5 j up");
    apply(3'b010, 3'b010, "R4 wrap beats inc j");
    apply(3'b111, 3'b101, "R4 mixed priority");
  endtask

  task automatic t_overrun;
    apply(3'b000, 3'b001, "R4 k restart");
    for (int t = 0; t < K_HI - K_LO + 3; t++) apply(3'b001, 3'b000, "R8 k past bound");
    for (int t = 0; t < 4; t++) apply(3'b010, 3'b000, "R8 j past bound");
  endtask

  task automatic t_burst;
    @(negedge clk);
    adv_i = 1'b1; inc_i = 3'b001; wrap_i = '0;
    for (int t = 0; t < 5; t++) begin
      mk++;
      @(negedge clk);
      chk(valid_o == 1'b1, "R2 burst valid", int'(valid_o), 1);
      chk(int'(val_o) == expv(mi, mj, mk), "R3 burst value", int'(val_o), expv(mi, mj, mk));
    end
    adv_i = 1'b0; inc_i = '0;
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 valid drops", int'(valid_o), 0);
  endtask

  task automatic t_mid_reset;
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    chk(val_o == '0 && valid_o == 1'b0, "R1 reset mid-run", int'(val_o), 0);
    rst_ni = 1'b1;
    mi = I_LO; mj = J_LO; mk = K_LO;
    apply(3'b001, 3'b000, "R1 state back at lower bounds");
  endtask

  initial begin
    mi = I_LO; mj = J_LO; mk = K_LO;
    @(negedge clk);
    t_reset;
    t_sweep;
    t_hold;
    t_prio;
    t_overrun;
    t_burst;
    t_mid_reset;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule